// File: doc/BRIEF.md
# SPI Host Transaction Sequencer

This block is a host-side SPI master for a graphics co-processor whose register and memory space is reached only in whole 32-bit words. A client hands it one request at a time: a write burst, a read burst or a five-byte host command. The block turns each request into a single framed SPI transfer on one mode 0 lane. Every memory access starts with a four-byte header. The header carries a direction flag and a word-aligned 31-bit address, sent high byte first. Data words travel low byte first.

Read bursts have no fixed dummy byte. After the header, the sequencer clocks in filler bytes until the target answers with the ready marker 0x01, and only the bytes after that marker are data. A per-request limit bounds this polling. If the limit runs out, the frame is closed with a timeout pulse instead of data. Host commands carry no address: five caller-supplied bytes are sent, for example all zeros for wake-up, or 0xFF, an opcode, a parameter, 0x00, 0x00 for a setting.

Top module: `spi_host_seq`

## Requirements
- R1: A write or read frame starts with four header bytes, most significant first. Header bit 31 is 1 for a write and 0 for a read. Bits 30..2 are req_addr[30:2]. Bits 1..0 are always 0, whatever req_addr[31] and req_addr[1:0] hold.
- R2: A write (req_op 2'b00) sends req_len words after the header, each word least significant byte first. wr_data is taken with one wr_take pulse per word. A req_len of 0 is treated as 1.
- R3: A read (req_op 2'b01) sends 0x00 bytes after the header and discards the returned bytes until one equals 0x01. Bytes returned during the header are never taken as the marker. The bytes after the marker form req_len words, least significant byte first. Each word is presented on rd_data with a one-cycle rd_valid pulse, in address order.
- R4: A read examines at most poll_limit poll bytes, with 0 treated as 1. A marker in the last permitted poll byte is still accepted.
- R5: If no marker arrives within the limit, the frame ends after exactly 4 + limit bytes. rd_timeout pulses once and rd_valid never pulses for that request.
- R6: A command (req_op[1] = 1) sends the five bytes of req_cmd, bits 39..32 first, with no header and no reply handling.
- R7: spi_ss_n is low for the whole frame and high for at least CLK_DIV clock cycles between frames. spi_sclk stays low while spi_ss_n is high.
- R8: SPI mode 0 is used. SCLK idles low and each SCLK half period lasts CLK_DIV/2 clock cycles. MOSI changes only while SCLK is low, and MISO is sampled as SCLK rises.
- R9: req_ready is high only while no frame is in progress, and each handshake starts exactly one frame. After reset, spi_ss_n is 1, spi_sclk is 0, req_ready is 1, and rd_valid, rd_timeout and wr_take are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_op | input | 2 | 00 write, 01 read, 1x command |
| req_addr | input | 32 | Word address (bits 30..2 used) |
| req_len | input | LEN_W | Words in the burst |
| req_cmd | input | 40 | Command bytes, bits 39..32 sent first |
| poll_limit | input | POLL_W | Maximum poll bytes on a read |
| wr_data | input | 32 | Write word to send next |
| wr_take | output | 1 | wr_data consumed, present the next word |
| rd_data | output | 32 | Read word |
| rd_valid | output | 1 | rd_data holds a new word |
| rd_timeout | output | 1 | Ready marker never arrived |
| spi_sclk | output | 1 | SPI clock |
| spi_mosi | output | 1 | Serial data to target |
| spi_miso | input | 1 | Serial data from target |
| spi_ss_n | output | 1 | Active-low target select |

## Verification
Two events can meet on the same received byte: the ready marker can arrive on the very poll byte where the limit runs out. The bench provokes this by placing 0x01 exactly at the limit-th poll position and checks that the data words come back with no timeout pulse. It places the marker one byte later and checks for a timeout after exactly 4 + limit bytes with no data. A second test keeps req_valid held through back-to-back requests, so that the end of one frame and the start of the next are as close as they can be. A monitor then measures the select-high gap and watches for stray SCLK edges.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_WDATA, ST_POLL, ST_RDATA, ST_CMD, ST_GAP
  } seq_state_t;

  localparam logic [7:0] READY_MARK = 8'h01;
  localparam logic [7:0] FILL_BYTE  = 8'h00;
  localparam int         HDR_BYTES  = 4;
  localparam int         CMD_BYTES  = 5;
endpackage

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
  parameter int CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int HALF = CLK_DIV / 2;

  logic       busy;
  logic [2:0] bit_cnt;
  logic [7:0] sh;
  logic       half_tick;

  generate
    if (HALF <= 1) begin : g_fast
      assign half_tick = 1'b1;
    end else begin : g_cnt
      localparam int HW = $clog2(HALF);
      logic [HW-1:0] hc;
      always_ff @(posedge clk) begin
        if (rst || !busy) hc <= '0;
        else if (hc == HW'(HALF - 1)) hc <= '0;
        else hc <= hc + 1'b1;
      end
      assign half_tick = (hc == HW'(HALF - 1));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
      bit_cnt <= '0;
      sh      <= '0;
      rx_byte <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          sh      <= tx_byte;
          mosi    <= tx_byte[7];
          bit_cnt <= '0;
        end
      end else if (half_tick) begin
        if (!sclk) begin
          sclk    <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_cnt == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            sh      <= {sh[6:0], 1'b0};
            mosi    <= sh[6];
          end
        end
      end
    end
  end

  // R8: data line holds still while the clock is high
  a_r8_mosi_hold: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));
  // R8: a byte ends with the clock back at its idle level
  a_r8_done_low: assert property (@(posedge clk) disable iff (rst)
    done |-> !sclk);
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_seq_pkg::*;
#(
  parameter int LEN_W   = 8,
  parameter int POLL_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [31:0]       req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [39:0]       req_cmd,
  input  logic [POLL_W-1:0] poll_limit,
  input  logic [31:0]       wr_data,
  output logic              wr_take,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              rd_timeout,
  output logic              ss_n,
  output logic              bs_start,
  output logic [7:0]        bs_tx,
  input  logic              bs_done,
  input  logic [7:0]        bs_rx
);
  localparam int GW = $clog2(CLK_DIV) + 1;

  seq_state_t        st;
  logic              waiting;
  logic [2:0]        idx;
  logic              is_read;
  logic [LEN_W-1:0]  len_q, wcnt;
  logic [POLL_W-1:0] lim_q, pcnt;
  logic [31:0]       hdr, wsh, rsh;
  logic [39:0]       cmd_q;
  logic [GW-1:0]     gap_cnt;
  logic              last_word;

  assign req_ready = (st == ST_IDLE);
  assign last_word = (wcnt == len_q - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      waiting    <= 1'b0;
      idx        <= '0;
      is_read    <= 1'b0;
      len_q      <= LEN_W'(1);
      wcnt       <= '0;
      lim_q      <= POLL_W'(1);
      pcnt       <= '0;
      hdr        <= '0;
      wsh        <= '0;
      rsh        <= '0;
      cmd_q      <= '0;
      gap_cnt    <= '0;
      ss_n       <= 1'b1;
      bs_start   <= 1'b0;
      bs_tx      <= '0;
      wr_take    <= 1'b0;
      rd_data    <= '0;
      rd_valid   <= 1'b0;
      rd_timeout <= 1'b0;
    end else begin
      bs_start   <= 1'b0;
      wr_take    <= 1'b0;
      rd_valid   <= 1'b0;
      rd_timeout <= 1'b0;

      // launch the next byte of the frame
      if (!waiting && st != ST_IDLE && st != ST_GAP) begin
        waiting  <= 1'b1;
        bs_start <= 1'b1;
        unique case (st)
          ST_ADDR: begin
            bs_tx <= hdr[31:24];
            hdr   <= {hdr[23:0], 8'h00};
          end
          ST_WDATA: begin
            if (idx == 3'd0) begin
              bs_tx   <= wr_data[7:0];
              wsh     <= {8'h00, wr_data[31:8]};
              wr_take <= 1'b1;
            end else begin
              bs_tx <= wsh[7:0];
              wsh   <= {8'h00, wsh[31:8]};
            end
          end
          ST_CMD: begin
            bs_tx <= cmd_q[39:32];
            cmd_q <= {cmd_q[31:0], 8'h00};
          end
          default: bs_tx <= FILL_BYTE;
        endcase
      end

      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            ss_n    <= 1'b0;
            idx     <= '0;
            wcnt    <= '0;
            pcnt    <= '0;
            is_read <= (req_op == 2'b01);
            len_q   <= (req_len == '0) ? LEN_W'(1) : req_len;
            lim_q   <= (poll_limit == '0) ? POLL_W'(1) : poll_limit;
            hdr     <= (req_addr & 32'h7FFF_FFFC) | {(req_op == 2'b00), 31'd0};
            cmd_q   <= req_cmd;
            st      <= req_op[1] ? ST_CMD : ST_ADDR;
          end
        end
        ST_GAP: begin
          if (gap_cnt == GW'(CLK_DIV - 1)) st <= ST_IDLE;
          else gap_cnt <= gap_cnt + 1'b1;
        end
        default: begin
          if (bs_done) begin
            waiting <= 1'b0;
            unique case (st)
              ST_ADDR: begin
                if (idx == 3'(HDR_BYTES - 1)) begin
                  idx <= '0;
                  st  <= is_read ? ST_POLL : ST_WDATA;
                end else idx <= idx + 1'b1;
              end
              ST_WDATA: begin
                if (idx == 3'd3) begin
                  idx <= '0;
                  if (last_word) begin
                    st <= ST_GAP; ss_n <= 1'b1; gap_cnt <= '0;
                  end else wcnt <= wcnt + 1'b1;
                end else idx <= idx + 1'b1;
              end
              ST_POLL: begin
                if (bs_rx == READY_MARK) begin
                  st  <= ST_RDATA;
                  idx <= '0;
                end else if (pcnt == lim_q - POLL_W'(1)) begin
                  rd_timeout <= 1'b1;
                  st <= ST_GAP; ss_n <= 1'b1; gap_cnt <= '0;
                end else pcnt <= pcnt + 1'b1;
              end
              ST_RDATA: begin
                rsh <= {bs_rx, rsh[31:8]};
                if (idx == 3'd3) begin
                  idx      <= '0;
                  rd_data  <= {bs_rx, rsh[31:8]};
                  rd_valid <= 1'b1;
                  if (last_word) begin
                    st <= ST_GAP; ss_n <= 1'b1; gap_cnt <= '0;
                  end else wcnt <= wcnt + 1'b1;
                end else idx <= idx + 1'b1;
              end
              ST_CMD: begin
                if (idx == 3'(CMD_BYTES - 1)) begin
                  st <= ST_GAP; ss_n <= 1'b1; gap_cnt <= '0;
                end else idx <= idx + 1'b1;
              end
              default: st <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  // R9: no request is accepted while a frame holds the target selected
  a_r9_ready_idle: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> ss_n);
  // R1: the last header byte leaves the two low address bits clear
  a_r1_addr_align: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ADDR && idx == 3'd3 && bs_start) |-> (bs_tx[1:0] == 2'b00));
  // R5: a timeout closes the frame and brings no data
  a_r5_timeout_close: assert property (@(posedge clk) disable iff (rst)
    rd_timeout |-> (ss_n && !rd_valid));
  // R2: write words are only consumed inside a frame
  a_r2_take_in_frame: assert property (@(posedge clk) disable iff (rst)
    wr_take |-> !ss_n);
  // R3: read words come from a frame that was open
  a_r3_valid_from_frame: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !$past(ss_n));
endmodule

// File: rtl/spi_host_seq.sv
module spi_host_seq #(
  parameter int LEN_W   = 8,
  parameter int POLL_W  = 8,
  parameter int CLK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [31:0]       req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [39:0]       req_cmd,
  input  logic [POLL_W-1:0] poll_limit,
  input  logic [31:0]       wr_data,
  output logic              wr_take,
  output logic [31:0]       rd_data,
  output logic              rd_valid,
  output logic              rd_timeout,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_ss_n
);
  logic       bs_start, bs_done;
  logic [7:0] bs_tx, bs_rx;

  spi_frame_ctl #(.LEN_W(LEN_W), .POLL_W(POLL_W), .CLK_DIV(CLK_DIV)) u_ctl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .req_cmd(req_cmd),
    .poll_limit(poll_limit), .wr_data(wr_data), .wr_take(wr_take),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_timeout(rd_timeout),
    .ss_n(spi_ss_n), .bs_start(bs_start), .bs_tx(bs_tx),
    .bs_done(bs_done), .bs_rx(bs_rx)
  );

  spi_byte_shifter #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk(clk), .rst(rst), .start(bs_start), .tx_byte(bs_tx),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi),
    .done(bs_done), .rx_byte(bs_rx)
  );

  // R7: the clock never toggles while the target is deselected
  a_r7_sclk_idle: assert property (@(posedge clk) disable iff (rst)
    spi_ss_n |-> !spi_sclk);
endmodule

// File: tb/tb_spi_host_seq.sv
module tb_spi_host_seq;
  localparam int LEN_W = 8, POLL_W = 8, CLK_DIV = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [31:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [39:0] req_cmd = '0;
  logic [POLL_W-1:0] poll_limit = '0;
  logic [31:0] wr_data, rd_data;
  logic wr_take, rd_valid, rd_timeout;
  logic spi_sclk, spi_mosi, spi_miso, spi_ss_n;

  always #4 clk = ~clk;

  spi_host_seq #(.LEN_W(LEN_W), .POLL_W(POLL_W), .CLK_DIV(CLK_DIV)) dut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  // target model
  logic [7:0] resp [0:63];
  logic [7:0] mlog [0:63];
  int mcnt = 0;
  logic [8:0] sbit = '0;
  logic [7:0] macc = '0;
  int mbits = 0;
  assign spi_miso = resp[sbit[8:3]][3'd7 - sbit[2:0]];
  always @(posedge spi_sclk) begin
    macc = {macc[6:0], spi_mosi};
    mbits++;
    if (mbits == 8) begin mlog[mcnt[5:0]] = macc; mcnt++; mbits = 0; end
  end
  always @(negedge spi_sclk) if (!spi_ss_n) sbit++;

  // user-side data
  logic [31:0] wwords [0:7];
  int widx = 0, wtakes = 0;
  assign wr_data = wwords[widx[2:0]];
  logic [31:0] rlog [0:7];
  int rcnt = 0, tcnt = 0;

  // monitors
  int ss_high = 0, min_gap = 1000, hi_run = 0, bad_half = 0, bad_mosi = 0;
  int stray_clk = 0, ready_busy = 0;
  logic prev_sclk = 0, prev_mosi = 0;
  always @(negedge clk) begin
    if (wr_take) begin wtakes++; widx++; end
    if (rd_valid) begin rlog[rcnt[2:0]] = rd_data; rcnt++; end
    if (rd_timeout) tcnt++;
    if (!rst) begin
      if (spi_ss_n) ss_high++;
      else begin
        if (ss_high > 0 && ss_high < min_gap) min_gap = ss_high;
        ss_high = 0;
      end
      if (spi_ss_n && spi_sclk) stray_clk++;
      if (req_ready && !spi_ss_n) ready_busy++;
      if (spi_sclk && prev_sclk && spi_mosi != prev_mosi) bad_mosi++;
      if (spi_sclk) hi_run++;
      else begin
        if (prev_sclk && hi_run != CLK_DIV / 2) bad_half++;
        hi_run = 0;
      end
      prev_sclk = spi_sclk;
      prev_mosi = spi_mosi;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_frame();
    mcnt = 0; mbits = 0; sbit = '0; rcnt = 0; tcnt = 0; wtakes = 0; widx = 0;
    for (int i = 0; i < 64; i++) begin resp[i] = 8'h00; mlog[i] = 8'h00; end
  endtask

  task automatic run_req(input logic [1:0] op, input logic [31:0] addr,
                         input int len, input logic [39:0] cmd, input int lim);
    @(negedge clk);
    req_op = op; req_addr = addr; req_len = LEN_W'(len); req_cmd = cmd;
    poll_limit = POLL_W'(lim); req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_reset();
    check(spi_ss_n === 1'b1, "R9 reset ss_n", 32'(spi_ss_n), 32'h1);
    check(spi_sclk === 1'b0, "R9 reset sclk", 32'(spi_sclk), 32'h0);
    check(req_ready === 1'b1, "R9 reset ready", 32'(req_ready), 32'h1);
    check({rd_valid, rd_timeout, wr_take} === 3'b000, "R9 reset strobes",
          32'({rd_valid, rd_timeout, wr_take}), 32'h0);
  endtask

  task automatic t_write();
    logic [7:0] exp [0:11];
    clear_frame();
    wwords[0] = 32'hA1B2C3D4; wwords[1] = 32'h0F1E2D3C;
    run_req(2'b00, 32'h8012_3457, 2, '0, 1);
    exp = '{8'h80, 8'h12, 8'h34, 8'h54, 8'hD4, 8'hC3, 8'hB2, 8'hA1,
            8'h3C, 8'h2D, 8'h1E, 8'h0F};
    check(mcnt == 12, "R2 write byte count", 32'(mcnt), 32'd12);
    for (int i = 0; i < 4; i++)
      check(mlog[i] == exp[i], "R1 write header", 32'(mlog[i]), 32'(exp[i]));
    for (int i = 4; i < 12; i++)
      check(mlog[i] == exp[i], "R2 write data order", 32'(mlog[i]), 32'(exp[i]));
    check(wtakes == 2, "R2 wr_take pulses", 32'(wtakes), 32'd2);
    // zero length acts as one word
    clear_frame();
    run_req(2'b00, 32'h0000_0100, 0, '0, 1);
    check(mcnt == 8 && wtakes == 1, "R2 zero length as one",
          32'(mcnt), 32'd8);
  endtask

  task automatic t_read_basic();
    clear_frame();
    resp[2] = 8'h01; resp[3] = 8'h01;          // marker inside header: ignored
    resp[4] = 8'h55; resp[5] = 8'h00; resp[6] = 8'h01;
    resp[7] = 8'h78; resp[8] = 8'h56; resp[9] = 8'h34; resp[10] = 8'h12;
    run_req(2'b01, 32'hFFFF_FFF8, 1, '0, 10);
    check(mlog[0] == 8'h7F && mlog[3] == 8'hF8, "R1 read header",
          {mlog[0], mlog[1], mlog[2], mlog[3]}, 32'h7FFFFFF8);
    check(rcnt == 1 && rlog[0] == 32'h12345678, "R3 read word",
          rlog[0], 32'h12345678);
    check(mcnt == 11, "R3 read frame length", 32'(mcnt), 32'd11);
    check(tcnt == 0, "R3 no timeout", 32'(tcnt), 32'd0);
  endtask

  task automatic t_read_boundary();
    clear_frame();
    resp[4] = 8'h55; resp[5] = 8'h02; resp[6] = 8'hFF; resp[7] = 8'h01;
    resp[8]  = 8'h11; resp[9]  = 8'h22; resp[10] = 8'h33; resp[11] = 8'h44;
    resp[12] = 8'hEE; resp[13] = 8'hDD; resp[14] = 8'hCC; resp[15] = 8'hBB;
    run_req(2'b01, 32'h0000_0040, 2, '0, 4);
    check(tcnt == 0, "R4 marker at limit no timeout", 32'(tcnt), 32'd0);
    check(rcnt == 2 && rlog[0] == 32'h44332211, "R4 word0 at limit",
          rlog[0], 32'h44332211);
    check(rlog[1] == 32'hBBCCDDEE, "R3 word order", rlog[1], 32'hBBCCDDEE);
  endtask

  task automatic t_timeout();
    clear_frame();
    resp[4] = 8'h55; resp[5] = 8'h55; resp[6] = 8'h55; resp[7] = 8'h55;
    resp[8] = 8'h01;                            // one byte too late
    run_req(2'b01, 32'h0000_0080, 1, '0, 4);
    check(tcnt == 1, "R5 timeout pulse", 32'(tcnt), 32'd1);
    check(rcnt == 0, "R5 no data", 32'(rcnt), 32'd0);
    check(mcnt == 8, "R5 frame bytes", 32'(mcnt), 32'd8);
    // limit of zero allows a single poll byte
    clear_frame();
    resp[4] = 8'h33; resp[5] = 8'h01;
    run_req(2'b01, 32'h0000_0080, 1, '0, 0);
    check(tcnt == 1 && mcnt == 5, "R4 zero limit as one", 32'(mcnt), 32'd5);
  endtask

  task automatic t_commands();
    clear_frame();
    run_req(2'b10, 32'hFFFF_FFFF, 3, 40'h00_0000_0000, 1);
    check(mcnt == 5 && mlog[0] == 8'h00 && mlog[4] == 8'h00, "R6 active cmd",
          32'(mcnt), 32'd5);
    clear_frame();
    run_req(2'b11, 32'h0, 1, 40'hFF_2005_0000, 1);
    check(mcnt == 5 && {mlog[0], mlog[1], mlog[2]} == 24'hFF2005 &&
          {mlog[3], mlog[4]} == 16'h0000, "R6 config cmd",
          {mlog[0], mlog[1], mlog[2], mlog[3]}, 32'hFF200500);
    check(wtakes == 0 && rcnt == 0, "R6 no data path", 32'(wtakes), 32'd0);
  endtask

  task automatic t_back_to_back();
    clear_frame();
    min_gap = 1000;
    @(negedge clk);
    req_op = 2'b10; req_cmd = 40'h01_0203_0405; req_valid = 1'b1;
    for (int n = 0; n < 3; n++) begin
      while (!req_ready) @(negedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!req_ready) @(negedge clk);
    check(min_gap >= CLK_DIV, "R7 deselect gap", 32'(min_gap), 32'(CLK_DIV));
    check(mcnt == 15, "R9 one frame per handshake", 32'(mcnt), 32'd15);
  endtask

  task automatic t_pin_rules();
    check(stray_clk == 0, "R7 sclk idle while deselected", 32'(stray_clk), 32'd0);
    check(bad_mosi == 0, "R8 mosi stable while sclk high", 32'(bad_mosi), 32'd0);
    check(bad_half == 0, "R8 sclk half period", 32'(bad_half), 32'd0);
    check(ready_busy == 0, "R9 ready low during frame", 32'(ready_busy), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) resp[i] = 8'h00;
    for (int i = 0; i < 8; i++) wwords[i] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_write();
    t_read_basic();
    t_read_boundary();
    t_timeout();
    t_commands();
    t_back_to_back();
    t_pin_rules();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule